// File: doc/BRIEF.md
# Micro-operation register datapath

This block is the execute half of a small processor: seven general-purpose registers, two source selectors, an arithmetic/logic unit and a destination decoder. Each clock cycle a single packed control word is presented. It names the two operands, the operation and the register that receives the result, so one word performs one register-transfer micro-operation such as "first register gets second minus third".

The ALU result is computed combinationally from the current control word and the current register contents. It always drives the output bus. At the rising clock edge it is loaded into the chosen destination register, if one is chosen. Either operand may be taken from an external input bus instead of a register, so the same word format loads constants and passes data straight through. All register contents are brought out on a flat port so that a caller can check them. The caller sequences the control words; this block holds no program state.

Top module: `rdp_top`

## Requirements
- R1: The 14-bit control word is split into four fields, from most to least significant: source A select in bits [13:11], source B select in bits [10:8], destination select in bits [7:5], and ALU opcode in bits [4:0].
- R2: A source select of 000 feeds the external input bus to that ALU operand. A source select of k from 1 to 7 feeds register Rk. Rk sits at bits [(k-1)*8 +: 8] of the register output port.
- R3: The opcodes give these results, all modulo 2^8: 00000 gives A; 00001 gives A+1; 00010 gives A+B; 00101 gives A-B; 00110 gives A-1; 01000 gives A AND B; 01010 gives A OR B; 01100 gives A XOR B; 01110 gives NOT A.
- R4: A destination select k from 1 to 7 loads Rk with the ALU output value present before the rising clock edge.
- R5: A destination select of 000 leaves every register unchanged.
- R6: Registers other than the selected destination keep their values across the edge.
- R7: Every opcode not listed in R3 or R8 produces an ALU output of zero.
- R8: Opcode 10000 shifts A right by one bit and opcode 11000 shifts A left by one bit. The vacated bit is zero in both cases.
- R9: While the active-low reset is asserted, all seven registers are cleared to zero.
- R10: The ALU output follows the control word, the input bus and the register contents within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears the registers |
| ctrlWord | input | 14 | Packed micro-operation control word |
| inBus | input | 8 | External input data bus |
| aluOut | output | 8 | ALU output bus |
| regsFlat | output | 56 | Contents of R1..R7, with R1 in the low byte |

## Verification
The bench builds the block with the default 8-bit data width. At this width the wrap cases come within reach: incrementing 0xFF, decrementing 0x00, subtracting a larger value, and shifting 0x81 in both directions are exercised directly. Directed words cover each opcode, each source code including the input bus, the no-destination code and several unused opcodes. A seeded stream of random control words then runs against a behavioural model, so every destination and source pairing is visited.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int SEL_W = 3;
  localparam int OPR_W = 5;
  localparam int CW_W = 3 * SEL_W + OPR_W;
  localparam int NUM_REGS = (1 << SEL_W) - 1;

  typedef enum logic [OPR_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } aluOp_e;

  typedef struct packed {
    logic [SEL_W-1:0]    srcA;
    logic [SEL_W-1:0]    srcB;
    logic [NUM_REGS-1:0] loadEn;
    logic [OPR_W-1:0]    op;
  } dpStrobes_t;
endpackage

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
(
  input  logic [CW_W-1:0] ctrlWord,
  output dpStrobes_t      strobes
);
  localparam int A_LSB = 2 * SEL_W + OPR_W;
  localparam int B_LSB = SEL_W + OPR_W;
  localparam int D_LSB = OPR_W;

  logic [SEL_W-1:0]    selD;
  logic [NUM_REGS-1:0] loadVec;

  assign selD = ctrlWord[D_LSB +: SEL_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign loadVec[i] = (selD == SEL_W'(i + 1));
  end

  always_comb begin
    strobes.srcA   = ctrlWord[A_LSB +: SEL_W];
    strobes.srcB   = ctrlWord[B_LSB +: SEL_W];
    strobes.loadEn = loadVec;
    strobes.op     = ctrlWord[OPR_W-1:0];
  end
endmodule

// File: rtl/rdp_alu.sv
module rdp_alu
  import rdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OPR_W-1:0]  op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    case (op)
      OP_PASS: result = opA;
      OP_INC:  result = opA + DATA_W'(1);
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_DEC:  result = opA - DATA_W'(1);
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      OP_NOT:  result = ~opA;
      OP_SHR:  result = {1'b0, opA[DATA_W-1:1]};
      OP_SHL:  result = {opA[DATA_W-2:0], 1'b0};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/rdp_datapath.sv
module rdp_datapath
  import rdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  dpStrobes_t                   strobes,
  input  logic [DATA_W-1:0]            inBus,
  output logic [DATA_W-1:0]            aluOut,
  output logic [NUM_REGS*DATA_W-1:0]   regsFlat
);
  localparam int SRC_N = 1 << SEL_W;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] srcTbl  [SRC_N];
  logic [DATA_W-1:0] busA;
  logic [DATA_W-1:0] busB;

  assign srcTbl[0] = inBus;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regFile[i] <= '0;
      end else if (strobes.loadEn[i]) begin
        regFile[i] <= aluOut;
      end
    end
    assign srcTbl[i+1]                 = regFile[i];
    assign regsFlat[i*DATA_W +: DATA_W] = regFile[i];
  end

  assign busA = srcTbl[strobes.srcA];
  assign busB = srcTbl[strobes.srcB];

  rdp_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (strobes.op),
    .opA    (busA),
    .opB    (busB),
    .result (aluOut)
  );
endmodule

// File: rtl/rdp_top.sv
module rdp_top
  import rdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CW_W-1:0]            ctrlWord,
  input  logic [DATA_W-1:0]          inBus,
  output logic [DATA_W-1:0]          aluOut,
  output logic [NUM_REGS*DATA_W-1:0] regsFlat
);
  dpStrobes_t strobes;

  rdp_ctrl u_ctrl (
    .ctrlWord (ctrlWord),
    .strobes  (strobes)
  );

  rdp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .inBus    (inBus),
    .aluOut   (aluOut),
    .regsFlat (regsFlat)
  );
endmodule

// File: rtl/rdp_checker.sv
module rdp_checker
  import rdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CW_W-1:0]            ctrlWord,
  input logic [DATA_W-1:0]          inBus,
  input logic [DATA_W-1:0]          aluOut,
  input logic [NUM_REGS*DATA_W-1:0] regsFlat
);
  logic [SEL_W-1:0] dstSel;
  logic [SEL_W-1:0] aSel;
  logic [OPR_W-1:0] opc;
  logic             opKnown;

  assign aSel   = ctrlWord[CW_W-1 -: SEL_W];
  assign dstSel = ctrlWord[OPR_W +: SEL_W];
  assign opc    = ctrlWord[OPR_W-1:0];
  assign opKnown = opc inside {5'b00000, 5'b00001, 5'b00010, 5'b00101,
                               5'b00110, 5'b01000, 5'b01010, 5'b01100,
                               5'b01110, 5'b10000, 5'b11000};

  // R9
  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (regsFlat == '0));

  // R5
  a_r5_no_dest_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dstSel == '0) |=> $stable(regsFlat));

  // R2 / R10
  a_r2_input_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (aSel == '0 && opc == '0) |-> (aluOut == inBus));

  // R7
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !opKnown |-> (aluOut == '0));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    // R4
    a_r4_dest_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (dstSel == SEL_W'(i + 1)) |=> (regsFlat[i*DATA_W +: DATA_W] == $past(aluOut)));
    // R6
    a_r6_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dstSel != SEL_W'(i + 1)) |=> $stable(regsFlat[i*DATA_W +: DATA_W]));
  end
endmodule

bind rdp_top rdp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrlWord (ctrlWord),
  .inBus    (inBus),
  .aluOut   (aluOut),
  .regsFlat (regsFlat)
);

// File: tb/tb_rdp_top.sv
`timescale 1ns/1ps
module tb_rdp_top;
  localparam int W = 8;
  localparam int NR = 7;
  localparam int MASK = (1 << W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [13:0]     ctrlWord = '0;
  logic [W-1:0]    inBus = '0;
  logic [W-1:0]    aluOut;
  logic [NR*W-1:0] regsFlat;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int model [NR];

  always #2.5 clk = ~clk;

  rdp_top #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ctrlWord(ctrlWord),
    .inBus(inBus), .aluOut(aluOut), .regsFlat(regsFlat)
  );

  function automatic int refAlu(int op, int a, int b);
    case (op)
      0:  return a;
      1:  return (a + 1) & MASK;
      2:  return (a + b) & MASK;
      5:  return (a - b) & MASK;
      6:  return (a - 1) & MASK;
      8:  return a & b;
      10: return a | b;
      12: return a ^ b;
      14: return (~a) & MASK;
      16: return a / 2;
      24: return (a * 2) & MASK;
      default: return 0;
    endcase
  endfunction

  function automatic int srcVal(int sel, int inv);
    return (sel == 0) ? inv : model[sel-1];
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic checkRegs(string tag);
    for (int k = 0; k < NR; k++)
      check(tag, $sformatf("R%0d", k + 1), int'(regsFlat[k*W +: W]), model[k]);
  endtask

  // fields: sa[13:11] sb[10:8] sd[7:5] op[4:0] (R1)
  task automatic step(int sa, int sb, int sd, int op, int inv, string tag);
    int expAlu;
    @(negedge clk);
    ctrlWord = {3'(sa), 3'(sb), 3'(sd), 5'(op)};
    inBus = W'(inv);
    #1;
    expAlu = refAlu(op, srcVal(sa, inv), srcVal(sb, inv));
    check(tag, "aluOut", int'(aluOut), expAlu);  // R10 same-cycle result
    @(posedge clk);
    if (sd != 0) model[sd-1] = expAlu;
    #1;
    checkRegs(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) model[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    checkRegs("R9");
    @(negedge clk);
    rst_n = 1'b1;
    inBus = 8'h5A;
    #1;
    check("R2", "aluOut passthrough", int'(aluOut), 'h5A);

    // R2 / R4: load constants through the input bus
    for (int k = 1; k <= NR; k++) step(0, 0, k, 0, 'h10 * k + 3, "R4");
    step(2, 3, 1, 5, 0, "R3");          // R1 <- R2 - R3
    step(6, 0, 6, 1, 0, "R3");          // R6 <- R6 + 1
    step(5, 5, 5, 12, 0, "R3");         // R5 cleared by self-XOR
    step(0, 0, 0, 0, 'hC3, "R5");       // pass-through, no load
    step(3, 4, 0, 2, 0, "R5");          // add, no destination
    step(0, 2, 3, 2, 'h7F, "R2");       // input bus on A
    step(4, 0, 4, 10, 'h0F, "R2");      // input bus on B
    step(0, 0, 7, 0, 'hFF, "R4");
    step(7, 0, 7, 1, 0, "R3");          // 0xFF + 1 wraps to 0
    step(7, 0, 2, 6, 0, "R3");          // 0 - 1 wraps to 0xFF
    step(1, 2, 3, 8, 0, "R3");
    step(3, 0, 3, 14, 0, "R3");
    step(1, 6, 4, 5, 0, "R3");
    step(0, 0, 1, 0, 'h81, "R4");
    step(1, 0, 2, 16, 0, "R8");         // 0x81 >> 1 = 0x40
    step(1, 0, 3, 24, 0, "R8");         // 0x81 << 1 = 0x02
    step(1, 1, 4, 3, 0, "R7");
    step(2, 3, 5, 31, 0, "R7");
    step(2, 3, 6, 20, 0, "R7");
    step(2, 3, 6, 17, 0, "R7");

    // R6: random stream against the model
    for (int n = 0; n < 300; n++) begin
      int opSel;
      int opTab [12] = '{0, 1, 2, 5, 6, 8, 10, 12, 14, 16, 24, 9};
      opSel = $urandom_range(11);
      step($urandom_range(7), $urandom_range(7), $urandom_range(7),
           opTab[opSel], $urandom_range(255), "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule